// File: doc/BRIEF.md
# System Control Register Bank

This block holds the memory-management and cache control state of a processor core, reached through coprocessor move requests. Each request names a primary register index, a secondary index, two opcode fields, a transfer register number, a direction and a 32-bit write value. The block answers one cycle later with read data and three status flags: error, warning and unsupported. It also drives the enable lines that the rest of the memory system uses: address translation, alignment checking, data cache, write buffer and instruction cache.

Writes to the TLB command index do not store anything. Each one becomes a single-cycle invalidate pulse, either for every entry or for one virtual address. Every index has its own access rule. The block stores a register only when the request is legal.

Top module: `sysctl_regbank`

## Requirements
- R1: After synchronous reset, all stored registers are zero, every response output and invalidate output is 0, and all five enable outputs are 0. A read of index 0 returns the identification parameter.
- R2: A request with a nonzero first opcode field, or with transfer register number 15, sets the error flag and does not set read-valid. No register changes.
- R3: Index 0 is read-only and returns the identification value. A write sets the error flag and is ignored. A read with a nonzero second opcode field still returns the value and sets the unsupported flag.
- R4: Index 1 is read and written as 32 bits. The enable outputs follow the stored bits: translation bit 0, alignment bit 1, data cache bit 2, write buffer bit 3, instruction cache bit 12.
- R5: A write to index 1 whose bit 7 (byte order) differs from the stored bit 7 sets both the error and the unsupported flag, and the register keeps its old value.
- R6: Index 2 stores and returns the write value ANDed with 0xFFFFC000. A write with any of bits [13:0] set raises the warning flag and is still accepted.
- R7: Index 3 and index 6 are plain 32-bit read/write registers.
- R8: Index 5 keeps bits [7:0] of a write. A read returns zero in bits [31:8].
- R9: Indexes 7 and 8 are write-only. A read of either sets the error flag with no read-valid. A write to index 7 sets no flag and changes nothing.
- R10: A write to index 8 with second opcode field 0 pulses the invalidate-all output for one cycle. Any other value of that field pulses the invalidate-one output instead, with the write value on the address output. The two pulses never occur together.
- R11: On index 13 (process ID, read/write), a nonzero second opcode field or secondary index raises the warning flag. The access still takes effect. The unsupported flag is set when the value written, or the stored value that is read, is nonzero.
- R12: Index 15 only sets the unsupported flag: a read gives no read-valid and a write stores nothing. Indexes 4, 9, 10, 11, 12 and 14 set the error flag.
- R13: Every response appears in the cycle after the request. Read-valid is high only for a legal read of a readable index, and read data is zero whenever read-valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_crn | input | 4 | Primary register index |
| req_crm | input | 4 | Secondary register index |
| req_op1 | input | 3 | First opcode field |
| req_op2 | input | 3 | Second opcode field |
| req_xreg | input | 4 | Transfer register number |
| req_wdata | input | 32 | Write value |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal access |
| rsp_warn | output | 1 | Accepted with warning |
| rsp_unsup | output | 1 | Unsupported feature touched |
| xlat_en | output | 1 | Address translation enable |
| align_chk | output | 1 | Alignment check enable |
| dcache_en | output | 1 | Data cache enable |
| wbuf_en | output | 1 | Write buffer enable |
| icache_en | output | 1 | Instruction cache enable |
| inv_all | output | 1 | Invalidate-all pulse |
| inv_one | output | 1 | Invalidate-one pulse |
| inv_vaddr | output | 32 | Address for invalidate-one |

## Verification
The assertions assume the request fields are known (not X) whenever req_valid is high. They also assume the checks that look back one cycle at the request refer to the request that was sampled at the last edge. The stimulus holds each request stable from one falling edge to the next, so each request is sampled at exactly one rising edge. Inputs are zero whenever no request is being driven. Random stimulus draws the first opcode field and the transfer register so that illegal requests are a minority. It biases the secondary fields toward zero, so the legal paths of every index are reached often.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DW        = 32;
    localparam int IDX_W     = 4;
    localparam int OP_W      = 3;
    localparam int FSR_W     = 8;
    localparam int TTB_ALIGN = 14;

    localparam logic [DW-1:0] TTB_MASK = {{(DW-TTB_ALIGN){1'b1}}, {TTB_ALIGN{1'b0}}};

    // control register bit positions decoded into enable outputs
    localparam int CB_XLAT  = 0;
    localparam int CB_ALIGN = 1;
    localparam int CB_DC    = 2;
    localparam int CB_WB    = 3;
    localparam int CB_BIG   = 7;
    localparam int CB_IC    = 12;

    typedef enum logic [3:0] {
        SEL_ID, SEL_CTRL, SEL_TTB, SEL_DAC, SEL_FSR, SEL_FAR,
        SEL_CACHE, SEL_TLB, SEL_PID, SEL_IMPL, SEL_NONE
    } sel_e;

    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] crn;
        logic [IDX_W-1:0] crm;
        logic [OP_W-1:0]  op1;
        logic [OP_W-1:0]  op2;
        logic [IDX_W-1:0] xreg;
        logic [DW-1:0]    wdata;
    } req_t;

    typedef struct packed {
        logic err;
        logic warn;
        logic unsup;
        logic wr_en;
        logic rd_en;
        logic inv_all;
        logic inv_one;
    } verdict_t;

    function automatic sel_e sel_of(input logic [IDX_W-1:0] crn);
        case (crn)
            4'd0:    return SEL_ID;
            4'd1:    return SEL_CTRL;
            4'd2:    return SEL_TTB;
            4'd3:    return SEL_DAC;
            4'd5:    return SEL_FSR;
            4'd6:    return SEL_FAR;
            4'd7:    return SEL_CACHE;
            4'd8:    return SEL_TLB;
            4'd13:   return SEL_PID;
            4'd15:   return SEL_IMPL;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int PC_IDX = 15
) (
    input  logic          req_valid,
    input  req_t          req,
    input  logic          big_q,
    input  logic [DW-1:0] pid_q,
    output sel_e          sel,
    output verdict_t      vd
);
    logic illegal;

    always_comb begin
        vd      = '0;
        sel     = sel_of(req.crn);
        illegal = (req.op1 != '0) || (req.xreg == IDX_W'(PC_IDX));
        if (req_valid) begin
            if (illegal) begin
                vd.err = 1'b1;
            end else begin
                case (sel)
                    SEL_ID: begin
                        if (req.wr) vd.err = 1'b1;
                        else begin
                            vd.rd_en = 1'b1;
                            vd.unsup = (req.op2 != '0);
                        end
                    end
                    SEL_CTRL: begin
                        if (req.wr) begin
                            if (req.wdata[CB_BIG] != big_q) begin
                                vd.err   = 1'b1;
                                vd.unsup = 1'b1;
                            end else begin
                                vd.wr_en = 1'b1;
                            end
                        end else begin
                            vd.rd_en = 1'b1;
                        end
                    end
                    SEL_TTB: begin
                        if (req.wr) begin
                            vd.wr_en = 1'b1;
                            vd.warn  = |(req.wdata & ~TTB_MASK);
                        end else begin
                            vd.rd_en = 1'b1;
                        end
                    end
                    SEL_DAC, SEL_FSR, SEL_FAR: begin
                        vd.wr_en = req.wr;
                        vd.rd_en = !req.wr;
                    end
                    SEL_CACHE: begin
                        vd.err = !req.wr;
                    end
                    SEL_TLB: begin
                        if (req.wr) begin
                            vd.inv_all = (req.op2 == '0);
                            vd.inv_one = (req.op2 != '0);
                        end else begin
                            vd.err = 1'b1;
                        end
                    end
                    SEL_PID: begin
                        vd.warn = (req.op2 != '0) || (req.crm != '0);
                        if (req.wr) begin
                            vd.wr_en = 1'b1;
                            vd.unsup = (req.wdata != '0);
                        end else begin
                            vd.rd_en = 1'b1;
                            vd.unsup = (pid_q != '0);
                        end
                    end
                    SEL_IMPL: vd.unsup = 1'b1;
                    default:  vd.err   = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE = 32'h4107_1A20
) (
    input  logic          clk,
    input  logic          rst,
    input  sel_e          sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] pid_q
);
    logic [DW-1:0]    ttb_q;
    logic [DW-1:0]    dac_q;
    logic [FSR_W-1:0] fsr_q;
    logic [DW-1:0]    far_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ttb_q  <= '0;
            dac_q  <= '0;
            fsr_q  <= '0;
            far_q  <= '0;
            pid_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: ctrl_q <= wdata;
                SEL_TTB:  ttb_q  <= wdata & TTB_MASK;
                SEL_DAC:  dac_q  <= wdata;
                SEL_FSR:  fsr_q  <= wdata[FSR_W-1:0];
                SEL_FAR:  far_q  <= wdata;
                SEL_PID:  pid_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:   rdata = ID_VALUE;
            SEL_CTRL: rdata = ctrl_q;
            SEL_TTB:  rdata = ttb_q;
            SEL_DAC:  rdata = dac_q;
            SEL_FSR:  rdata = {{(DW-FSR_W){1'b0}}, fsr_q};
            SEL_FAR:  rdata = far_q;
            SEL_PID:  rdata = pid_q;
            default:  rdata = '0;
        endcase
    end

    // base register never holds bits below its alignment
    assert_ttb_align_R6: assert property (@(posedge clk) disable iff (rst)
        (ttb_q & ~TTB_MASK) == '0);
endmodule

// File: rtl/sysctl_resp.sv
module sysctl_resp
    import sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  verdict_t      vd,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic          rsp_warn,
    output logic          rsp_unsup,
    output logic          inv_all,
    output logic          inv_one,
    output logic [DW-1:0] inv_vaddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            rsp_warn  <= 1'b0;
            rsp_unsup <= 1'b0;
            inv_all   <= 1'b0;
            inv_one   <= 1'b0;
            inv_vaddr <= '0;
        end else begin
            rsp_valid <= vd.rd_en;
            rsp_rdata <= vd.rd_en ? rdata : '0;
            rsp_err   <= vd.err;
            rsp_warn  <= vd.warn;
            rsp_unsup <= vd.unsup;
            inv_all   <= vd.inv_all;
            inv_one   <= vd.inv_one;
            if (vd.inv_one) inv_vaddr <= wdata;
        end
    end

    assert_inv_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(inv_all && inv_one));
    assert_rdv_noerr_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !rsp_err);
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4107_1A20,
    parameter int          PC_IDX   = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op1,
    input  logic [2:0]  req_op2,
    input  logic [3:0]  req_xreg,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        rsp_warn,
    output logic        rsp_unsup,
    output logic        xlat_en,
    output logic        align_chk,
    output logic        dcache_en,
    output logic        wbuf_en,
    output logic        icache_en,
    output logic        inv_all,
    output logic        inv_one,
    output logic [31:0] inv_vaddr
);
    req_t          req;
    sel_e          sel;
    verdict_t      vd;
    logic [DW-1:0] rdata;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] pid_q;

    assign req = '{wr: req_write, crn: req_crn, crm: req_crm, op1: req_op1,
                   op2: req_op2, xreg: req_xreg, wdata: req_wdata};

    sysctl_decode #(.PC_IDX(PC_IDX)) u_decode (
        .req_valid (req_valid),
        .req       (req),
        .big_q     (ctrl_q[CB_BIG]),
        .pid_q     (pid_q),
        .sel       (sel),
        .vd        (vd)
    );

    sysctl_store #(.ID_VALUE(ID_VALUE)) u_store (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wr_en  (vd.wr_en),
        .wdata  (req_wdata),
        .rdata  (rdata),
        .ctrl_q (ctrl_q),
        .pid_q  (pid_q)
    );

    sysctl_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .vd        (vd),
        .rdata     (rdata),
        .wdata     (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .rsp_warn  (rsp_warn),
        .rsp_unsup (rsp_unsup),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_vaddr (inv_vaddr)
    );

    assign xlat_en   = ctrl_q[CB_XLAT];
    assign align_chk = ctrl_q[CB_ALIGN];
    assign dcache_en = ctrl_q[CB_DC];
    assign wbuf_en   = ctrl_q[CB_WB];
    assign icache_en = ctrl_q[CB_IC];

    // an error response means the control state did not move at that edge
    assert_err_hold_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $stable(ctrl_q));
    // fault status reads never carry upper bits
    assert_fsr_narrow_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_valid && !req_write && req_crn == 4'd5))
            |-> (rsp_rdata[31:FSR_W] == '0));
    // invalidate-all only follows a legal TLB write with second opcode zero
    assert_inv_cause_R10: assert property (@(posedge clk) disable iff (rst)
        inv_all |-> $past(req_valid && req_write && req_crn == 4'd8 &&
                          req_op2 == '0 && req_op1 == '0 &&
                          req_xreg != 4'(PC_IDX)));
endmodule

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
module sysctl_regbank_tb;
    localparam logic [31:0] IDV = 32'h4107_1A20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_crn = '0, req_crm = '0, req_xreg = '0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_warn, rsp_unsup;
    logic [31:0] rsp_rdata, inv_vaddr;
    logic        xlat_en, align_chk, dcache_en, wbuf_en, icache_en, inv_all, inv_one;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_ctrl, m_ttb, m_dac, m_fsr, m_far, m_pid;

    always #2.5 clk = ~clk;

    sysctl_regbank #(.ID_VALUE(IDV), .PC_IDX(15)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_crn(req_crn), .req_crm(req_crm), .req_op1(req_op1), .req_op2(req_op2),
        .req_xreg(req_xreg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_warn(rsp_warn),
        .rsp_unsup(rsp_unsup), .xlat_en(xlat_en), .align_chk(align_chk),
        .dcache_en(dcache_en), .wbuf_en(wbuf_en), .icache_en(icache_en),
        .inv_all(inv_all), .inv_one(inv_one), .inv_vaddr(inv_vaddr)
    );

    function automatic logic [4:0] en_of(input logic [31:0] c);
        return {c[12], c[3], c[2], c[1], c[0]};
    endfunction

    // {valid, err, warn, unsup, inv_all, inv_one}
    task automatic xfer(input bit w, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op1, input logic [2:0] op2,
                        input logic [3:0] xr, input logic [31:0] d, input string tag);
        logic [5:0]  ef, af;
        logic [31:0] er;
        bit v = 0, e = 0, wn = 0, u = 0, ia = 0, io = 0;
        er = '0;
        if (op1 != 0 || xr == 4'd15) e = 1;
        else case (crn)
            4'd0: if (w) e = 1; else begin v = 1; er = IDV; u = (op2 != 0); end
            4'd1: if (w) begin
                      if (d[7] != m_ctrl[7]) begin e = 1; u = 1; end else m_ctrl = d;
                  end else begin v = 1; er = m_ctrl; end
            4'd2: if (w) begin wn = (d[13:0] != 0); m_ttb = d & 32'hFFFF_C000; end
                  else begin v = 1; er = m_ttb; end
            4'd3: if (w) m_dac = d; else begin v = 1; er = m_dac; end
            4'd5: if (w) m_fsr = {24'h0, d[7:0]}; else begin v = 1; er = m_fsr; end
            4'd6: if (w) m_far = d; else begin v = 1; er = m_far; end
            4'd7: e = !w;
            4'd8: if (w) begin ia = (op2 == 0); io = (op2 != 0); end else e = 1;
            4'd13: begin
                wn = (op2 != 0) || (crm != 0);
                if (w) begin m_pid = d; u = (d != 0); end
                else begin v = 1; er = m_pid; u = (m_pid != 0); end
            end
            4'd15: u = 1;
            default: e = 1;
        endcase
        ef = {v, e, wn, u, ia, io};
        req_valid = 1; req_write = w; req_crn = crn; req_crm = crm;
        req_op1 = op1; req_op2 = op2; req_xreg = xr; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_crn = 0; req_crm = 0;
        req_op1 = 0; req_op2 = 0; req_xreg = 0; req_wdata = 0;
        af = {rsp_valid, rsp_err, rsp_warn, rsp_unsup, inv_all, inv_one};
        checks++;
        if (af !== ef || rsp_rdata !== er || (io && inv_vaddr !== d) ||
            {icache_en, wbuf_en, dcache_en, align_chk, xlat_en} !== en_of(m_ctrl)) begin
            errors++;
            $display("FAIL %s crn=%0d w=%0d flags act=%b exp=%b rdata act=%h exp=%h vaddr act=%h exp=%h en act=%b exp=%b",
                     tag, crn, w, af, ef, rsp_rdata, er, inv_vaddr, io ? d : inv_vaddr,
                     {icache_en, wbuf_en, dcache_en, align_chk, xlat_en}, en_of(m_ctrl));
        end
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        checks++;
        if ({rsp_valid, rsp_err, rsp_warn, rsp_unsup, inv_all, inv_one} !== 6'b0 || rsp_rdata !== 32'h0) begin
            errors++;
            $display("FAIL %s idle outputs act=%b/%h exp=000000/00000000", tag,
                     {rsp_valid, rsp_err, rsp_warn, rsp_unsup, inv_all, inv_one}, rsp_rdata);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_ctrl = 0; m_ttb = 0; m_dac = 0; m_fsr = 0; m_far = 0; m_pid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        checks++;
        if ({rsp_valid, rsp_err, rsp_warn, rsp_unsup, inv_all, inv_one, xlat_en, align_chk,
             dcache_en, wbuf_en, icache_en} !== 11'b0 || rsp_rdata !== 0 || inv_vaddr !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs nonzero act=%h exp=0", rsp_rdata);
        end
        xfer(0, 4'd0, 0, 0, 0, 4'd1, 0, "R1 id after reset");
        xfer(0, 4'd3, 0, 0, 0, 4'd1, 0, "R1 dac after reset");
        // R3
        xfer(0, 4'd0, 0, 0, 3'd1, 4'd2, 0, "R3 id op2 nonzero");
        xfer(1, 4'd0, 0, 0, 0, 4'd2, 32'hFFFF_FFFF, "R3 id write");
        xfer(0, 4'd0, 0, 0, 0, 4'd2, 0, "R3 id unchanged");
        // R4
        xfer(1, 4'd1, 0, 0, 0, 4'd3, 32'h0000_100F, "R4 ctrl write");
        xfer(0, 4'd1, 0, 0, 0, 4'd3, 0, "R4 ctrl read");
        xfer(1, 4'd1, 0, 0, 0, 4'd3, 32'h0000_0005, "R4 ctrl partial");
        // R5
        xfer(1, 4'd1, 0, 0, 0, 4'd3, 32'h0000_108F, "R5 endian change");
        xfer(0, 4'd1, 0, 0, 0, 4'd3, 0, "R5 ctrl kept");
        // R2
        xfer(1, 4'd3, 0, 3'd2, 0, 4'd4, 32'h1111_2222, "R2 op1 nonzero");
        xfer(1, 4'd3, 0, 0, 0, 4'd15, 32'h3333_4444, "R2 pc transfer");
        xfer(0, 4'd1, 0, 3'd1, 0, 4'd4, 0, "R2 illegal read");
        xfer(0, 4'd3, 0, 0, 0, 4'd4, 0, "R2 dac untouched");
        // R6
        xfer(1, 4'd2, 0, 0, 0, 4'd5, 32'h1234_5678, "R6 ttb unaligned");
        xfer(0, 4'd2, 0, 0, 0, 4'd5, 0, "R6 ttb masked");
        xfer(1, 4'd2, 0, 0, 0, 4'd5, 32'hABCD_C000, "R6 ttb aligned");
        xfer(0, 4'd2, 0, 0, 0, 4'd5, 0, "R6 ttb read");
        // R7
        xfer(1, 4'd3, 0, 0, 0, 4'd6, 32'h5555_AAAA, "R7 dac write");
        xfer(0, 4'd3, 0, 0, 0, 4'd6, 0, "R7 dac read");
        xfer(1, 4'd6, 0, 0, 0, 4'd6, 32'hC0DE_F00D, "R7 far write");
        xfer(0, 4'd6, 0, 0, 0, 4'd6, 0, "R7 far read");
        // R8
        xfer(1, 4'd5, 0, 0, 0, 4'd7, 32'hDEAD_BEEF, "R8 fsr write");
        xfer(0, 4'd5, 0, 0, 0, 4'd7, 0, "R8 fsr read");
        // R9
        xfer(0, 4'd7, 0, 0, 0, 4'd8, 0, "R9 cache read");
        xfer(0, 4'd8, 0, 0, 0, 4'd8, 0, "R9 tlb read");
        xfer(1, 4'd7, 0, 0, 0, 4'd8, 32'h0000_0001, "R9 cache write");
        xfer(0, 4'd1, 0, 0, 0, 4'd8, 0, "R9 ctrl after cache write");
        // R10
        xfer(1, 4'd8, 4'd7, 0, 0, 4'd9, 32'h1234_0000, "R10 inv all");
        idle_check("R10 inv all single cycle");
        xfer(1, 4'd8, 4'd7, 0, 3'd1, 4'd9, 32'h8000_1000, "R10 inv one");
        idle_check("R10 inv one single cycle");
        xfer(1, 4'd8, 0, 0, 3'd5, 4'd9, 32'h0040_2000, "R10 inv one op2 5");
        // R11
        xfer(0, 4'd13, 4'd1, 0, 0, 4'd10, 0, "R11 pid crm warn");
        xfer(0, 4'd13, 0, 0, 3'd2, 4'd10, 0, "R11 pid op2 warn");
        xfer(1, 4'd13, 0, 0, 0, 4'd10, 32'h0000_0005, "R11 pid nonzero");
        xfer(0, 4'd13, 0, 0, 0, 4'd10, 0, "R11 pid read nonzero");
        xfer(1, 4'd13, 0, 0, 0, 4'd10, 0, "R11 pid clear");
        // R12
        xfer(0, 4'd15, 0, 0, 0, 4'd11, 0, "R12 impl read");
        xfer(1, 4'd15, 0, 0, 0, 4'd11, 32'hFFFF_FFFF, "R12 impl write");
        xfer(0, 4'd4, 0, 0, 0, 4'd11, 0, "R12 index 4");
        xfer(1, 4'd9, 0, 0, 0, 4'd11, 1, "R12 index 9");
        xfer(0, 4'd14, 0, 0, 0, 4'd11, 0, "R12 index 14");
        // R13
        idle_check("R13 no request");
        for (int i = 0; i < 400; i++) begin
            logic [2:0] o1, o2;
            logic [3:0] cm, xr;
            o1 = ($urandom % 8 == 0) ? 3'($urandom % 7 + 1) : 3'd0;
            o2 = ($urandom % 2 == 0) ? 3'($urandom) : 3'd0;
            cm = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
            xr = 4'($urandom);
            xfer(1'($urandom), 4'($urandom), cm, o1, o2, xr, $urandom, "R13 random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule